// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets a clocked host read and write a 32K x 8 asynchronous static RAM. The host presents one access at a time on a request/ready handshake: address, write data and a read/write flag. Reads return their byte with a single-cycle valid strobe. On the memory side the block drives a 15-bit address, three active-low strobes (select, output enable, write enable) and a split data bus (out, in and a drive enable) that the chip level joins into one bidirectional pad.

All memory timing comes from nanosecond limits. Each limit is turned into a clock-cycle count by rounding up after dividing by the clock period. A speed-grade parameter picks the 70 ns or the 85 ns set of limits. A write is framed by select and write enable falling together and rising together. Address and data are held steady across that whole window. A read keeps select and output enable low until the access time has run out. The byte is captured at that edge, and a bus turnaround gap follows before the block may drive the bus again.

Top module: `sram_access_ctrl`

## Requirements
- R1: While reset (synchronous, active high) is asserted, and on the first cycle after it, all three memory strobes are high (inactive), the data bus is not driven, read-valid is low and ready is high.
- R2: A read holds select and output enable low and write enable high for RD cycles, where RD is the rounded-up cycle count of the largest of access time, output-enable access time and read cycle time. The byte on the data input at the RD-th clock edge after acceptance appears on read data with read-valid high for exactly one cycle.
- R3: A write pulls select and write enable low on the same edge and keeps both low for exactly WP cycles. WP is the rounded-up cycle count of the largest of write pulse width, select-to-end-of-write, address-to-end-of-write and data setup. Output enable stays high while write enable is low.
- R4: The memory address stays unchanged while select is low, and the write data stays unchanged while the bus is driven.
- R5: The data bus is driven only while both select and write enable are low.
- R6: After a read, ready stays low for TA more cycles, where TA is the rounded-up cycle count of the output release time (25 ns). The bus is therefore first driven at least TA cycles after output enable rises. For a read, ready returns RD+TA edges after acceptance.
- R7: After a write, ready returns max(WP, WC) edges after acceptance, where WC is the rounded-up write cycle time. Successive accesses therefore start at least one write cycle apart.
- R8: A request is accepted only on an edge where ready is high. A request raised and dropped while ready is low starts no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_req | input | 1 | Access request, taken when host_ready is high |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Word address |
| host_wdata | input | DATA_W | Byte to write |
| host_ready | output | 1 | Controller idle, a request is taken at the next edge |
| host_rdata | output | DATA_W | Captured read byte |
| host_rvalid | output | 1 | One-cycle strobe marking host_rdata |
| mem_addr | output | ADDR_W | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | DATA_W | Data driven toward the memory |
| mem_dq_in | input | DATA_W | Data returned by the memory |
| mem_dq_oe | output | 1 | High while the controller drives the data bus |

## Verification
The bench builds the controller with the 70 ns grade and a 10 ns clock. With these values RD is 7, WP is 6, TA is 3, and the write cycle count of 7 exceeds WP, so the recovery path after a write is exercised rather than skipped. The behavioural memory returns a garbage byte until select and output enable have been low for the full access count. A read captured one edge early is therefore visible as wrong data. The memory also records the length of each write window and the gap from output release to the next bus drive, so exact strobe widths and turnaround are checked at the pins.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef struct packed {
    int unsigned rd_cycle_ns;
    int unsigned addr_acc_ns;
    int unsigned oe_acc_ns;
    int unsigned release_ns;
    int unsigned wr_cycle_ns;
    int unsigned wr_pulse_ns;
    int unsigned sel_to_end_ns;
    int unsigned addr_to_end_ns;
    int unsigned data_setup_ns;
  } sram_timing_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR,
    ST_WREC,
    ST_RD,
    ST_TURN
  } ctrl_state_t;

  function automatic sram_timing_t grade_timing(input int unsigned grade);
    sram_timing_t t;
    if (grade == 85) begin
      t.rd_cycle_ns    = 85;
      t.addr_acc_ns    = 85;
      t.oe_acc_ns      = 40;
      t.release_ns     = 25;
      t.wr_cycle_ns    = 85;
      t.wr_pulse_ns    = 60;
      t.sel_to_end_ns  = 70;
      t.addr_to_end_ns = 70;
      t.data_setup_ns  = 35;
    end else begin
      t.rd_cycle_ns    = 70;
      t.addr_acc_ns    = 70;
      t.oe_acc_ns      = 35;
      t.release_ns     = 25;
      t.wr_cycle_ns    = 70;
      t.wr_pulse_ns    = 50;
      t.sel_to_end_ns  = 60;
      t.addr_to_end_ns = 60;
      t.data_setup_ns  = 25;
    end
    return t;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Rounded-up conversion of a nanosecond limit into clock cycles.
  function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned period);
    return (ns + period - 1) / period;
  endfunction

  function automatic int unsigned read_cycles(input sram_timing_t t, input int unsigned period);
    int unsigned c;
    c = umax(ns_to_cycles(t.addr_acc_ns, period), ns_to_cycles(t.oe_acc_ns, period));
    c = umax(c, ns_to_cycles(t.rd_cycle_ns, period));
    return umax(c, 1);
  endfunction

  function automatic int unsigned write_cycles(input sram_timing_t t, input int unsigned period);
    int unsigned c;
    c = umax(ns_to_cycles(t.wr_pulse_ns, period), ns_to_cycles(t.sel_to_end_ns, period));
    c = umax(c, ns_to_cycles(t.addr_to_end_ns, period));
    c = umax(c, ns_to_cycles(t.data_setup_ns, period));
    return umax(c, 1);
  endfunction

  function automatic int unsigned recover_cycles(input sram_timing_t t, input int unsigned period);
    int unsigned wc;
    int unsigned wp;
    wc = ns_to_cycles(t.wr_cycle_ns, period);
    wp = write_cycles(t, period);
    return (wc > wp) ? (wc - wp) : 0;
  endfunction

  function automatic int unsigned turn_cycles(input sram_timing_t t, input int unsigned period);
    return ns_to_cycles(t.release_ns, period);
  endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned RD_CYC  = 7,
  parameter int unsigned WP_CYC  = 6,
  parameter int unsigned REC_CYC = 1,
  parameter int unsigned TA_CYC  = 3,
  parameter int unsigned CNT_W   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             req_we,
  input  logic             tmr_zero,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             accept,
  output logic             wr_end,
  output logic             rd_capture,
  output logic             ready,
  output logic             cs_n,
  output logic             oe_n,
  output logic             we_n,
  output logic             bus_drive,
  output ctrl_state_t      state
);

  localparam logic [CNT_W-1:0] RD_LD  = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LD  = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] REC_LD = CNT_W'((REC_CYC > 0) ? REC_CYC - 1 : 0);
  localparam logic [CNT_W-1:0] TA_LD  = CNT_W'((TA_CYC > 0) ? TA_CYC - 1 : 0);

  ctrl_state_t after_wr;
  ctrl_state_t after_rd;
  logic        rec_load;
  logic        ta_load;

  // The parameters decide whether a recovery or turnaround state exists.
  if (REC_CYC > 0) begin : g_rec
    assign after_wr = ST_WREC;
    assign rec_load = 1'b1;
  end else begin : g_norec
    assign after_wr = ST_IDLE;
    assign rec_load = 1'b0;
  end

  if (TA_CYC > 0) begin : g_ta
    assign after_rd = ST_TURN;
    assign ta_load  = 1'b1;
  end else begin : g_nota
    assign after_rd = ST_IDLE;
    assign ta_load  = 1'b0;
  end

  assign ready      = (state == ST_IDLE);
  assign accept     = ready && req;
  assign wr_end     = (state == ST_WR) && tmr_zero;
  assign rd_capture = (state == ST_RD) && tmr_zero;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (accept) begin
      tmr_load = 1'b1;
      tmr_val  = req_we ? WP_LD : RD_LD;
    end else if (wr_end && rec_load) begin
      tmr_load = 1'b1;
      tmr_val  = REC_LD;
    end else if (rd_capture && ta_load) begin
      tmr_load = 1'b1;
      tmr_val  = TA_LD;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cs_n      <= 1'b1;
      oe_n      <= 1'b1;
      we_n      <= 1'b1;
      bus_drive <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            cs_n <= 1'b0;
            if (req_we) begin
              we_n      <= 1'b0;
              bus_drive <= 1'b1;
              state     <= ST_WR;
            end else begin
              oe_n  <= 1'b0;
              state <= ST_RD;
            end
          end
        end
        ST_WR: begin
          if (tmr_zero) begin
            cs_n      <= 1'b1;
            we_n      <= 1'b1;
            bus_drive <= 1'b0;
            state     <= after_wr;
          end
        end
        ST_WREC: begin
          if (tmr_zero) state <= ST_IDLE;
        end
        ST_RD: begin
          if (tmr_zero) begin
            cs_n  <= 1'b1;
            oe_n  <= 1'b1;
            state <= after_rd;
          end
        end
        ST_TURN: begin
          if (tmr_zero) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              rd_capture,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rvalid
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr    <= '0;
      mem_dq_out  <= '0;
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
    end else begin
      if (accept) begin
        mem_addr   <= host_addr;
        mem_dq_out <= host_wdata;
      end
      if (rd_capture) host_rdata <= mem_dq_in;
      host_rvalid <= rd_capture;
    end
  end

endmodule

// File: rtl/sram_access_ctrl.sv
module sram_access_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 15,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter int unsigned SPEED_GRADE   = 70
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_ready,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rvalid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_dq_oe
);

  localparam sram_timing_t TIM     = grade_timing(SPEED_GRADE);
  localparam int unsigned  RD_CYC  = read_cycles(TIM, CLK_PERIOD_NS);
  localparam int unsigned  WP_CYC  = write_cycles(TIM, CLK_PERIOD_NS);
  localparam int unsigned  REC_CYC = recover_cycles(TIM, CLK_PERIOD_NS);
  localparam int unsigned  TA_CYC  = turn_cycles(TIM, CLK_PERIOD_NS);
  localparam int unsigned  MAX_CYC = umax(umax(RD_CYC, WP_CYC), umax(REC_CYC, TA_CYC));
  localparam int unsigned  CNT_W   = $clog2(MAX_CYC + 1);

  // Named internal events, shared with the bound checker.
  logic             ev_accept;
  logic             ev_wr_end;
  logic             ev_rd_capture;
  logic             tmr_load;
  logic             tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  ctrl_state_t      ctrl_state;

  sram_ctrl_timer #(
    .CNT_W(CNT_W)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .load_val(tmr_val),
    .zero    (tmr_zero)
  );

  sram_ctrl_fsm #(
    .RD_CYC (RD_CYC),
    .WP_CYC (WP_CYC),
    .REC_CYC(REC_CYC),
    .TA_CYC (TA_CYC),
    .CNT_W  (CNT_W)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req       (host_req),
    .req_we    (host_we),
    .tmr_zero  (tmr_zero),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .accept    (ev_accept),
    .wr_end    (ev_wr_end),
    .rd_capture(ev_rd_capture),
    .ready     (host_ready),
    .cs_n      (mem_cs_n),
    .oe_n      (mem_oe_n),
    .we_n      (mem_we_n),
    .bus_drive (mem_dq_oe),
    .state     (ctrl_state)
  );

  sram_ctrl_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .accept     (ev_accept),
    .rd_capture (ev_rd_capture),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .mem_dq_in  (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .host_rdata (host_rdata),
    .host_rvalid(host_rvalid)
  );

endmodule

// File: rtl/sram_access_ctrl_chk.sv
module sram_access_ctrl_chk #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned WP_CYC = 6,
  parameter int unsigned TA_CYC = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_cs_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_dq_oe,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              host_ready,
  input logic              host_rvalid,
  input logic              ev_wr_end
);

  logic [15:0] we_low_cnt;
  logic [15:0] released_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_low_cnt   <= '0;
      released_cnt <= 16'hFFFF;
    end else begin
      we_low_cnt <= mem_we_n ? 16'd0 : we_low_cnt + 16'd1;
      if (!mem_oe_n)                   released_cnt <= '0;
      else if (released_cnt != 16'hFFFF) released_cnt <= released_cnt + 16'd1;
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe && !host_rvalid && host_ready));

  p_rvalid_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    host_rvalid |=> !host_rvalid);

  p_rw_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
    !(!mem_we_n && !mem_oe_n));

  p_pulse_width_r3: assert property (@(posedge clk) disable iff (rst)
    ev_wr_end |-> (!mem_we_n && we_low_cnt == 16'(WP_CYC - 1)));

  p_addr_stable_r4: assert property (@(posedge clk) disable iff (rst)
    (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr));

  p_wdata_stable_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

  p_drive_in_write_r5: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> (!mem_we_n && !mem_cs_n));

  p_turnaround_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_dq_oe) |-> (released_cnt >= 16'(TA_CYC)));

  p_ready_idle_r8: assert property (@(posedge clk) disable iff (rst)
    host_ready |-> (mem_cs_n && mem_oe_n && mem_we_n));

endmodule

bind sram_access_ctrl sram_access_ctrl_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .WP_CYC(WP_CYC),
  .TA_CYC(TA_CYC)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mem_cs_n   (mem_cs_n),
  .mem_oe_n   (mem_oe_n),
  .mem_we_n   (mem_we_n),
  .mem_dq_oe  (mem_dq_oe),
  .mem_addr   (mem_addr),
  .mem_dq_out (mem_dq_out),
  .host_ready (host_ready),
  .host_rvalid(host_rvalid),
  .ev_wr_end  (ev_wr_end)
);

// File: tb/test_sram_access_ctrl.sv
module test_sram_access_ctrl;

  localparam int T_NS = 10;

  // Expected counts restated from the requirements: quotient plus one on remainder.
  function automatic int up(input int ns);
    return ns / T_NS + ((ns % T_NS) != 0 ? 1 : 0);
  endfunction

  localparam int EXP_RD  = 7;   // up(70) dominates up(35)
  localparam int EXP_WP  = 6;   // up(60) dominates up(50), up(25)
  localparam int EXP_WC  = 7;   // up(70)
  localparam int EXP_TA  = 3;   // up(25)

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_req = 1'b0;
  logic        host_we = 1'b0;
  logic [14:0] host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic        host_ready;
  logic [7:0]  host_rdata;
  logic        host_rvalid;
  logic [14:0] mem_addr;
  logic        mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in;

  always #5 clk = ~clk;

  sram_access_ctrl i_sram_access_ctrl (
    .clk(clk), .rst(rst),
    .host_req(host_req), .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_ready(host_ready), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
  );

  // ---------------- behavioural memory ----------------
  logic [7:0]  mdl [logic [14:0]];
  logic [7:0]  mdl_data = '0;
  int          rd_age = 0;
  logic        rd_prev = 1'b0;
  logic [14:0] rd_prev_addr = '0;
  int          wlen = 0;
  int          last_wlen = 0;
  int          wr_count = 0;
  logic [14:0] wa = '0;
  logic [7:0]  wd = '0;
  bit          wr_unstable = 1'b0;
  bit          bad_drive = 1'b0;
  int          hz_age = 255;
  int          min_gap = 255;
  logic        oe_prev = 1'b0;

  function automatic logic [7:0] lookup(input logic [14:0] a);
    return mdl.exists(a) ? mdl[a] : 8'h00;
  endfunction

  wire rd_active = !mem_cs_n && !mem_oe_n && mem_we_n;
  assign mem_dq_in = (rd_active && rd_age >= EXP_RD - 1) ? mdl_data : 8'hA5;

  always @(posedge clk) begin
    mdl_data <= lookup(mem_addr);
    if (rd_active) rd_age <= (rd_prev && mem_addr == rd_prev_addr) ? rd_age + 1 : 1;
    else           rd_age <= 0;
    rd_prev      <= rd_active;
    rd_prev_addr <= mem_addr;

    if (!mem_cs_n && !mem_we_n) begin
      if (wlen != 0 && (mem_addr != wa || mem_dq_out != wd)) wr_unstable <= 1'b1;
      wlen <= wlen + 1;
      wa   <= mem_addr;
      wd   <= mem_dq_out;
    end else if (wlen != 0) begin
      mdl[wa]   = wd;
      last_wlen <= wlen;
      wr_count  <= wr_count + 1;
      wlen      <= 0;
    end

    if (mem_dq_oe && (mem_we_n || mem_cs_n || !mem_oe_n)) bad_drive <= 1'b1;
    if (mem_oe_n) hz_age <= (hz_age < 255) ? hz_age + 1 : hz_age;
    else          hz_age <= 0;
    if (mem_dq_oe && !oe_prev && hz_age < min_gap) min_gap <= hz_age;
    oe_prev <= mem_dq_oe;
  end

  // ---------------- check bookkeeping ----------------
  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_op(input logic w, input logic [14:0] a, input logic [7:0] d,
                         output int lat_r, output int lat_v, output int pulses,
                         output logic [7:0] rd);
    @(negedge clk);
    while (!host_ready) @(negedge clk);
    host_req = 1'b1; host_we = w; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_req = 1'b0;
    lat_r = -1; lat_v = -1; pulses = 0; rd = '0;
    for (int n = 0; n < 64; n++) begin
      if (host_rvalid) begin
        pulses++;
        if (lat_v < 0) begin lat_v = n; rd = host_rdata; end
      end
      if (host_ready) begin lat_r = n; break; end
      @(negedge clk);
    end
  endtask

  // {write flag, address, data (written, or expected on read)}
  localparam logic [23:0] VEC [11] = '{
    {1'b1, 15'h0000, 8'h3C}, {1'b1, 15'h7FFF, 8'hC3}, {1'b1, 15'h1234, 8'h5A},
    {1'b0, 15'h0000, 8'h3C}, {1'b0, 15'h7FFF, 8'hC3}, {1'b1, 15'h0000, 8'h81},
    {1'b0, 15'h1234, 8'h5A}, {1'b0, 15'h0000, 8'h81}, {1'b1, 15'h4001, 8'hFF},
    {1'b0, 15'h4001, 8'hFF}, {1'b0, 15'h2222, 8'h00}
  };

  initial begin
    int lr, lv, np, wc0;
    logic [7:0] rd;

    repeat (3) @(negedge clk);
    // R1: reset state
    check(mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe && !host_rvalid && host_ready,
          "R1 reset idle", {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, host_rvalid, host_ready}, 6'b111001);
    rst = 1'b0;
    @(negedge clk);
    check(mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe && host_ready,
          "R1 idle after release", {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, host_ready}, 5'b11101);

    foreach (VEC[i]) begin
      host_op(VEC[i][23], VEC[i][22:8], VEC[i][7:0], lr, lv, np, rd);
      if (VEC[i][23]) begin
        check(last_wlen == EXP_WP, "R3 write window cycles", last_wlen, EXP_WP);
        check(lr == ((EXP_WC > EXP_WP) ? EXP_WC : EXP_WP), "R7 write ready latency", lr, EXP_WC);
        check(!wr_unstable, "R4 address/data steady in write", wr_unstable, 0);
      end else begin
        check(rd == VEC[i][7:0], "R2 read data", rd, VEC[i][7:0]);
        check(lv == EXP_RD, "R2 read valid latency", lv, EXP_RD);
        check(np == 1, "R2 one valid pulse", np, 1);
        check(lr == EXP_RD + EXP_TA, "R6 read ready latency", lr, EXP_RD + EXP_TA);
      end
    end

    // R6: read followed at once by a write keeps the release gap
    host_op(1'b0, 15'h7FFF, 8'h00, lr, lv, np, rd);
    host_op(1'b1, 15'h0F0F, 8'h6E, lr, lv, np, rd);
    check(min_gap >= EXP_TA, "R6 release gap before drive", min_gap, EXP_TA);
    check(!bad_drive, "R5 bus driven only inside write", bad_drive, 0);
    host_op(1'b0, 15'h0F0F, 8'h00, lr, lv, np, rd);
    check(rd == 8'h6E, "R2 read after turnaround", rd, 8'h6E);

    // R8: request raised while busy is dropped
    @(negedge clk);
    wc0 = wr_count;
    host_req = 1'b1; host_we = 1'b0; host_addr = 15'h0000;
    @(negedge clk);
    host_req = 1'b0;
    repeat (2) @(negedge clk);
    check(!host_ready, "R8 busy during read", host_ready, 0);
    host_req = 1'b1; host_we = 1'b1; host_addr = 15'h5555; host_wdata = 8'h77;
    @(negedge clk);
    host_req = 1'b0;
    while (!host_ready) @(negedge clk);
    repeat (2) @(negedge clk);
    check(wr_count == wc0, "R8 no write from busy request", wr_count, wc0);
    host_op(1'b0, 15'h5555, 8'h00, lr, lv, np, rd);
    check(rd == 8'h00, "R8 dropped write left memory", rd, 8'h00);

    // R1: reset in the middle of a write releases the strobes and bus
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b1; host_addr = 15'h6000; host_wdata = 8'h11;
    @(negedge clk);
    host_req = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && host_ready,
          "R1 reset mid write", {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, host_ready}, 5'b11101);
    rst = 1'b0;
    host_op(1'b0, 15'h1234, 8'h00, lr, lv, np, rd);
    check(rd == 8'h5A, "R2 read after reset", rd, 8'h5A);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    if (up(70) != EXP_RD || up(60) != EXP_WP || up(25) != EXP_TA) begin
      n_chk++;
      n_fail++;
      $display("FAIL bench constants actual=%0h expected=%0h", up(70), EXP_RD);
    end
  end

endmodule